// File: doc/BRIEF.md
# Binarized Multichannel 3x3 Convolution Engine

This block is a streaming convolution layer for a fixed-point neural network. Each input beat carries one pixel position of eight 16-bit signed feature maps. The block slides a 3x3 window over all eight maps at once. Every weight is a single sign bit, so each tap adds or subtracts the pixel and no multiplier is needed in the window datapath. For each of eight output channels it sums the signed taps over all eight inputs. It then applies a per-channel fixed-point scale and a bias, which together hold a batch normalization folded into the layer. Finally it can clamp negative results to zero, and it emits one 128-bit beat per output pixel.

Image width and height are set on configuration inputs. Borders are zero padded, so the output map has the same size as the input map. Weights, scales and biases are written through a plain register write port while no frame is in flight, and they stay fixed for the whole frame. Input and output streams move at the same time. When the consumer withholds ready, the whole window pipeline freezes.

Top module: `bconv3x3_engine`

## Requirements
- R1: After reset, m_tvalid is low, and the block is ready for the first input pixel whenever m_tready is high.
- R2: Output channel o at pixel (y,x) is sat(((A*scale_o) >>> 8) + bias_o). A is the sum over the eight input channels i and over ky,kx in 0..2 of ±in_i(y+ky-1, x+kx-1). Pixels outside the image count as zero. Tap bit k = 3*ky+kx of the weight word for (o,i) selects + when it is 1 and - when it is 0, with ky=0 the row above the centre and kx=0 the column to its left.
- R3: A result above 32767 leaves as 32767, and a result below -32768 leaves as -32768. It never wraps.
- R4: When relu_en is high, a negative result leaves as 0. Positive results are unchanged.
- R5: A frame of W x H input pixels yields exactly W*H output beats in raster order, and m_tlast is high on the last of them only.
- R6: While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values and s_tready stays low.
- R7: Output channel o occupies m_tdata bits [16*o+15:16*o], and input channel i occupies s_tdata bits [16*i+15:16*i].
- R8: Parameter writes use three ranges. Address 8*o+i writes weight word (o,i) from prm_wdata[8:0]. Address 64+o writes scale_o, a signed value with 8 fraction bits. Address 72+o writes bias_o, a signed 16-bit value.
- R9: Frames can follow each other without reset, and no pixel of one frame affects the padding or the results of the next.
- R10: A 1x1 frame and a frame as wide as MAX_W are both processed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | XW | Image width W, 1 to MAX_W |
| cfg_height | input | YW | Image height H, 1 to MAX_H |
| relu_en | input | 1 | Clamp negative results to zero |
| prm_we | input | 1 | Parameter write strobe |
| prm_addr | input | PAW | Parameter address |
| prm_wdata | input | 16 | Parameter write data |
| s_tdata | input | 128 | Input pixel, eight channels |
| s_tvalid | input | 1 | Input valid |
| s_tready | output | 1 | Input ready |
| m_tdata | output | 128 | Output pixel, eight channels |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tlast | output | 1 | Last pixel of the frame |

## Verification
The hardest case to reach is a stall from the consumer that lands during the padding steps. In these steps the scanner runs with no input, at the end of a row or in the extra row after the last line. A stall there also tends to meet the frame boundary, where the next frame's first pixels are already queued behind it. The bench drives both streams with random valid and ready probabilities, some of them low. It runs frames back to back under one configuration, with fresh data and no reset between them. Saturation needs extreme accumulations, so one frame drives every input to a large constant, with all-add weights on half the channels and all-subtract weights on the other half.

// File: rtl/bconv_pkg.sv
package bconv_pkg;
  localparam int unsigned KSIDE = 3;
  localparam int unsigned KTAPS = KSIDE * KSIDE;

  typedef enum logic [1:0] {
    PRM_WGT   = 2'd0,
    PRM_SCALE = 2'd1,
    PRM_BIAS  = 2'd2,
    PRM_NONE  = 2'd3
  } prm_region_e;

  // Decode a flat parameter address into its region, given the channel count.
  function automatic prm_region_e prm_region(input int unsigned addr, input int unsigned nch);
    if (addr < nch * nch)                return PRM_WGT;
    else if (addr < nch * nch + nch)     return PRM_SCALE;
    else if (addr < nch * nch + 2 * nch) return PRM_BIAS;
    else                                 return PRM_NONE;
  endfunction
endpackage

// File: rtl/bconv_linebuf.sv
// One image line of packed pixels. Write port and asynchronous read port share one address.
module bconv_linebuf #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 33,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bconv_window.sv
// Raster scanner over an extended (W+1)x(H+1) grid. Real positions consume input.
// Positions on the extra column or row inject zeros, which gives right and bottom padding.
module bconv_window
  import bconv_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 16,
  parameter int MAX_W = 32,
  parameter int MAX_H = 32,
  localparam int XW   = $clog2(MAX_W + 1),
  localparam int YW   = $clog2(MAX_H + 1),
  localparam int BW   = NCH * DW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [XW-1:0]             cfg_width,
  input  logic [YW-1:0]             cfg_height,
  input  logic [BW-1:0]             s_data,
  input  logic                      s_valid,
  output logic                      s_ready,
  output logic [NCH*KTAPS*DW-1:0]   win_o,
  output logic                      win_valid,
  output logic                      win_last
);
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          x_pad, real_c, emit_c, last_c, step;
  logic [BW-1:0] bot_c, mid_c, top_c;
  logic [BW-1:0] lb_rd [2];
  logic [BW-1:0] lb_wd [2];
  logic [BW-1:0] wq [KSIDE][KSIDE];  // [column][row], column 2 newest, row 0 top

  assign x_pad  = (x_q == cfg_width);
  assign real_c = !x_pad && (y_q != cfg_height);
  assign emit_c = (x_q != '0) && (y_q != '0);
  assign last_c = x_pad && (y_q == cfg_height);
  assign step   = en && (!real_c || s_valid);
  assign s_ready = en && real_c;

  // Line buffers chained: stage 0 holds the previous row, stage 1 the row before it.
  assign lb_wd[0] = bot_c;
  assign lb_wd[1] = lb_rd[0];

  for (genvar g = 0; g < 2; g++) begin : g_line
    bconv_linebuf #(
      .WIDTH(BW),
      .DEPTH(MAX_W + 1),
      .AW   (XW)
    ) u_line (
      .clk  (clk),
      .we   (step),
      .addr (x_q),
      .wdata(lb_wd[g]),
      .rdata(lb_rd[g])
    );
  end

  // Rows not yet written in this frame and the pad column read as zero.
  assign bot_c = real_c ? s_data : '0;
  assign mid_c = (!x_pad && (y_q != '0))      ? lb_rd[0] : '0;
  assign top_c = (!x_pad && (y_q > YW'(1)))   ? lb_rd[1] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (x_pad) begin
        x_q <= '0;
        y_q <= (y_q == cfg_height) ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      for (int c = 0; c < KSIDE - 1; c++) begin
        for (int r = 0; r < KSIDE; r++) wq[c][r] <= wq[c+1][r];
      end
      wq[KSIDE-1][0] <= top_c;
      wq[KSIDE-1][1] <= mid_c;
      wq[KSIDE-1][2] <= bot_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_last  <= 1'b0;
    end else if (en) begin
      win_valid <= step && emit_c;
      win_last  <= step && last_c;
    end
  end

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      for (int r = 0; r < KSIDE; r++) begin
        for (int c = 0; c < KSIDE; c++) begin
          win_o[(ch*KTAPS + r*KSIDE + c)*DW +: DW] = wq[c][r][ch*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/bconv_mac.sv
// Sign-bit tap sums: stage 1 reduces nine taps per (output, input) pair, stage 2 sums inputs.
module bconv_mac
  import bconv_pkg::*;
#(
  parameter int NIN  = 8,
  parameter int NOUT = 8,
  parameter int DW   = 16,
  parameter int AW   = 24,
  localparam int PW  = DW + $clog2(KTAPS) + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [NIN*KTAPS*DW-1:0]      win_i,
  input  logic                         valid_i,
  input  logic                         last_i,
  input  logic [NOUT*NIN*KTAPS-1:0]    wgt_i,
  output logic [NOUT*AW-1:0]           acc_o,
  output logic                         valid_o,
  output logic                         last_o
);
  logic v1_q, l1_q;

  function automatic logic signed [PW-1:0] tap_sum(input logic [KTAPS*DW-1:0] px,
                                                   input logic [KTAPS-1:0]    w);
    logic signed [PW-1:0] s;
    s = '0;
    for (int k = 0; k < KTAPS; k++) begin
      if (w[k]) s = s + PW'(signed'(px[k*DW +: DW]));
      else      s = s - PW'(signed'(px[k*DW +: DW]));
    end
    return s;
  endfunction

  for (genvar oc = 0; oc < NOUT; oc++) begin : g_out
    logic signed [PW-1:0] part_q [NIN];
    logic signed [AW-1:0] sum_c;
    logic signed [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
      if (en) begin
        for (int ic = 0; ic < NIN; ic++) begin
          part_q[ic] <= tap_sum(win_i[ic*KTAPS*DW +: KTAPS*DW],
                                wgt_i[(oc*NIN + ic)*KTAPS +: KTAPS]);
        end
      end
    end

    always_comb begin
      sum_c = '0;
      for (int ic = 0; ic < NIN; ic++) sum_c = sum_c + AW'(part_q[ic]);
    end

    always_ff @(posedge clk) begin
      if (en) acc_q <= sum_c;
    end

    assign acc_o[oc*AW +: AW] = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0; l1_q <= 1'b0;
      valid_o <= 1'b0; last_o <= 1'b0;
    end else if (en) begin
      v1_q <= valid_i;  l1_q <= last_i;
      valid_o <= v1_q;  last_o <= l1_q;
    end
  end
endmodule

// File: rtl/bconv_affine.sv
// Folded batch-norm step: scale with FRAC fraction bits, bias, saturate, optional clamp at zero.
module bconv_affine #(
  parameter int NCH  = 8,
  parameter int AW   = 24,
  parameter int SW   = 16,
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                relu_en,
  input  logic [NCH*AW-1:0]   acc_i,
  input  logic                valid_i,
  input  logic                last_i,
  input  logic [NCH*SW-1:0]   scale_i,
  input  logic [NCH*SW-1:0]   bias_i,
  output logic [NCH*DW-1:0]   data_o,
  output logic                valid_o,
  output logic                last_o
);
  localparam int VW = AW + SW + 1;
  localparam logic signed [VW-1:0] VMAX = VW'((2 ** (DW - 1)) - 1);
  localparam logic signed [VW-1:0] VMIN = -VW'(2 ** (DW - 1));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [AW-1:0]    a_c;
    logic signed [SW-1:0]    s_c, b_c;
    logic signed [AW+SW-1:0] p_c;
    logic signed [VW-1:0]    v_c;
    logic signed [DW-1:0]    r_c, q_q;

    assign a_c = acc_i[ch*AW +: AW];
    assign s_c = scale_i[ch*SW +: SW];
    assign b_c = bias_i[ch*SW +: SW];

    always_comb begin
      p_c = a_c * s_c;
      v_c = VW'(p_c >>> FRAC) + VW'(b_c);
      if (v_c > VMAX)      r_c = DW'(VMAX);
      else if (v_c < VMIN) r_c = DW'(VMIN);
      else                 r_c = v_c[DW-1:0];
      if (relu_en && r_c[DW-1]) r_c = '0;
    end

    always_ff @(posedge clk) begin
      if (en) q_q <= r_c;
    end

    assign data_o[ch*DW +: DW] = q_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (en) begin
      valid_o <= valid_i;
      last_o  <= last_i;
    end
  end
endmodule

// File: rtl/bconv3x3_engine.sv
module bconv3x3_engine
  import bconv_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 16,
  parameter int AW    = 24,
  parameter int SW    = 16,
  parameter int FRAC  = 8,
  parameter int MAX_W = 32,
  parameter int MAX_H = 32,
  localparam int XW   = $clog2(MAX_W + 1),
  localparam int YW   = $clog2(MAX_H + 1),
  localparam int NW   = NCH * NCH,
  localparam int PAW  = $clog2(NW + 2 * NCH),
  localparam int BW   = NCH * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [XW-1:0]  cfg_width,
  input  logic [YW-1:0]  cfg_height,
  input  logic           relu_en,
  input  logic           prm_we,
  input  logic [PAW-1:0] prm_addr,
  input  logic [SW-1:0]  prm_wdata,
  input  logic [BW-1:0]  s_tdata,
  input  logic           s_tvalid,
  output logic           s_tready,
  output logic [BW-1:0]  m_tdata,
  output logic           m_tvalid,
  input  logic           m_tready,
  output logic           m_tlast
);
  logic [NW*KTAPS-1:0]      wgt_q;
  logic [NCH*SW-1:0]        scale_q;
  logic [NCH*SW-1:0]        bias_q;
  logic                     en;
  logic [NCH*KTAPS*DW-1:0]  win;
  logic                     win_valid, win_last;
  logic [NCH*AW-1:0]        acc;
  logic                     acc_valid, acc_last;
  prm_region_e              region;
  int unsigned              pa;

  // One stall signal for every stage: advance when the output slot is empty or draining.
  assign en = !m_tvalid || m_tready;

  assign pa     = int'(prm_addr);
  assign region = prm_region(pa, NCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      wgt_q <= '1;
      bias_q <= '0;
      for (int i = 0; i < NCH; i++) scale_q[i*SW +: SW] <= SW'(1 << FRAC);
    end else if (prm_we) begin
      unique case (region)
        PRM_WGT:   wgt_q[pa*KTAPS +: KTAPS]        <= prm_wdata[KTAPS-1:0];
        PRM_SCALE: scale_q[(pa - NW)*SW +: SW]     <= prm_wdata;
        PRM_BIAS:  bias_q[(pa - NW - NCH)*SW +: SW] <= prm_wdata;
        default: ;
      endcase
    end
  end

  bconv_window #(
    .NCH(NCH), .DW(DW), .MAX_W(MAX_W), .MAX_H(MAX_H)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cfg_width (cfg_width),
    .cfg_height(cfg_height),
    .s_data    (s_tdata),
    .s_valid   (s_tvalid),
    .s_ready   (s_tready),
    .win_o     (win),
    .win_valid (win_valid),
    .win_last  (win_last)
  );

  bconv_mac #(
    .NIN(NCH), .NOUT(NCH), .DW(DW), .AW(AW)
  ) u_mac (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .win_i  (win),
    .valid_i(win_valid),
    .last_i (win_last),
    .wgt_i  (wgt_q),
    .acc_o  (acc),
    .valid_o(acc_valid),
    .last_o (acc_last)
  );

  bconv_affine #(
    .NCH(NCH), .AW(AW), .SW(SW), .DW(DW), .FRAC(FRAC)
  ) u_affine (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .relu_en(relu_en),
    .acc_i  (acc),
    .valid_i(acc_valid),
    .last_i (acc_last),
    .scale_i(scale_q),
    .bias_i (bias_q),
    .data_o (m_tdata),
    .valid_o(m_tvalid),
    .last_o (m_tlast)
  );
endmodule

// File: rtl/bconv_chk.sv
module bconv_chk #(
  parameter int XW = 6,
  parameter int YW = 6,
  parameter int BW = 128,
  localparam int CW = XW + YW
) (
  input logic          clk,
  input logic          rst,
  input logic [XW-1:0] cfg_width,
  input logic [YW-1:0] cfg_height,
  input logic          s_tready,
  input logic [BW-1:0] m_tdata,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic          m_tlast
);
  logic [CW-1:0] beat_q;
  logic [CW-1:0] last_idx;

  assign last_idx = CW'(cfg_width) * CW'(cfg_height) - CW'(1);

  always_ff @(posedge clk) begin
    if (rst)                               beat_q <= '0;
    else if (m_tvalid && m_tready)         beat_q <= m_tlast ? '0 : beat_q + 1'b1;
  end

  // R1: the output stream is empty right after reset
  p_reset_empty_r1: assert property (@(posedge clk) $past(rst) |-> !m_tvalid);

  // R6: a stalled beat keeps its content and blocks new input
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
  p_stall_in_r6: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |-> !s_tready);

  // R5: frame end marker sits on beat W*H-1 and nowhere else
  p_last_pos_r5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tready && m_tlast |-> beat_q == last_idx);
  p_not_last_r5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tready && !m_tlast |-> beat_q != last_idx);
endmodule

bind bconv3x3_engine bconv_chk #(.XW(XW), .YW(YW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_width (cfg_width),
  .cfg_height(cfg_height),
  .s_tready  (s_tready),
  .m_tdata   (m_tdata),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready),
  .m_tlast   (m_tlast)
);

// File: tb/test_bconv3x3_engine.sv
module test_bconv3x3_engine;
  localparam int NCH = 8, DW = 16, SW = 16, FRAC = 8, MAX_W = 32, MAX_H = 32;
  localparam int XW  = $clog2(MAX_W + 1);
  localparam int YW  = $clog2(MAX_H + 1);
  localparam int PAW = $clog2(NCH * NCH + 2 * NCH);
  localparam int BW  = NCH * DW;

  logic           clk = 1'b0;
  logic           rst;
  logic [XW-1:0]  cfg_width;
  logic [YW-1:0]  cfg_height;
  logic           relu_en;
  logic           prm_we;
  logic [PAW-1:0] prm_addr;
  logic [SW-1:0]  prm_wdata;
  logic [BW-1:0]  s_tdata;
  logic           s_tvalid;
  logic           s_tready;
  logic [BW-1:0]  m_tdata;
  logic           m_tvalid;
  logic           m_tready;
  logic           m_tlast;

  bconv3x3_engine i_bconv3x3_engine (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int img [NCH][MAX_H][MAX_W];
  logic [8:0] wb [NCH][NCH];
  int sc [NCH];
  int bi [NCH];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_prm(input int addr, input int data);
    @(negedge clk);
    prm_we = 1'b1; prm_addr = PAW'(addr); prm_wdata = SW'(data);
    @(negedge clk);
    prm_we = 1'b0;
  endtask

  task automatic load_all();
    for (int o = 0; o < NCH; o++)
      for (int i = 0; i < NCH; i++) wr_prm(o*NCH + i, int'(wb[o][i]));
    for (int o = 0; o < NCH; o++) wr_prm(NCH*NCH + o, sc[o]);
    for (int o = 0; o < NCH; o++) wr_prm(NCH*NCH + NCH + o, bi[o]);
  endtask

  task automatic rand_params();
    for (int o = 0; o < NCH; o++) begin
      for (int i = 0; i < NCH; i++) wb[o][i] = 9'($urandom);
      sc[o] = int'($urandom_range(512, 32));
      bi[o] = int'($urandom_range(2000, 0)) - 1000;
    end
  endtask

  task automatic fill_img(input int w, input int h, input int mode);
    for (int i = 0; i < NCH; i++)
      for (int y = 0; y < h; y++)
        for (int x = 0; x < w; x++)
          case (mode)
            0: img[i][y][x] = i*7 + y*5 + x*3 - 40;
            1: img[i][y][x] = int'($urandom_range(4000, 0)) - 2000;
            2: img[i][y][x] = 30000;
            default: img[i][y][x] = int'($urandom_range(65535, 0)) - 32768;
          endcase
  endtask

  function automatic int expect_px(int o, int y, int x, int w, int h, bit relu);
    longint acc = 0;
    longint v;
    for (int i = 0; i < NCH; i++)
      for (int ky = 0; ky < 3; ky++)
        for (int kx = 0; kx < 3; kx++) begin
          int yy = y + ky - 1;
          int xx = x + kx - 1;
          if (yy >= 0 && yy < h && xx >= 0 && xx < w) begin
            if (wb[o][i][ky*3 + kx]) acc += img[i][yy][xx];
            else                     acc -= img[i][yy][xx];
          end
        end
    v = (acc * sc[o]) >>> FRAC;
    v = v + bi[o];
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    if (relu && v < 0) v = 0;
    return int'(v);
  endfunction

  function automatic logic [BW-1:0] pack_in(int idx, int w);
    logic [BW-1:0] v;
    int y = idx / w;
    int x = idx % w;
    for (int i = 0; i < NCH; i++) v[i*DW +: DW] = DW'(img[i][y][x]);
    return v;
  endfunction

  task automatic run_frame(input int w, input int h, input bit relu,
                           input int vp, input int rp, input string req);
    int n = w * h;
    int sent = 0, got = 0, cyc = 0;
    bit sfire = 0, hold = 0;
    logic [BW-1:0] hd;
    logic hl;
    @(negedge clk);
    cfg_width = XW'(w); cfg_height = YW'(h); relu_en = relu;
    s_tvalid = 1'b0; m_tready = 1'b0;
    while (got < n) begin
      @(negedge clk);
      cyc++;
      if (sfire) begin sent++; s_tvalid = 1'b0; end
      if (!s_tvalid && sent < n && int'($urandom_range(99, 0)) < vp) begin
        s_tvalid = 1'b1;
        s_tdata  = pack_in(sent, w);
      end
      m_tready = (int'($urandom_range(99, 0)) < rp);
      #1;
      if (hold) chk(m_tvalid && m_tdata == hd && m_tlast == hl, "R6",
                    "stalled beat changed", longint'(m_tvalid), 1);
      sfire = s_tvalid && s_tready;
      if (m_tvalid && m_tready) begin
        for (int o = 0; o < NCH; o++) begin
          int act = int'(signed'(m_tdata[o*DW +: DW]));
          int exp = expect_px(o, got / w, got % w, w, h, relu);
          chk(act == exp, req, $sformatf("pixel %0d ch %0d", got, o), act, exp);
        end
        chk(m_tlast == (got == n - 1), "R5", $sformatf("tlast at beat %0d", got),
            longint'(m_tlast), longint'(got == n - 1));
        got++;
      end
      hold = m_tvalid && !m_tready;
      hd = m_tdata; hl = m_tlast;
      if (cyc > 20000) begin
        chk(0, req, "frame did not complete", got, n);
        break;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0; m_tready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; relu_en = 1'b0; prm_we = 1'b0; prm_addr = '0; prm_wdata = '0;
    s_tdata = '0; s_tvalid = 1'b0; m_tready = 1'b1;
    cfg_width = XW'(4); cfg_height = YW'(3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", longint'(m_tvalid), 0);
    chk(s_tready == 1'b1, "R1", "s_tready after reset", longint'(s_tready), 1);

    // R7: all-add weights, unity scale, ramp data, full throughput
    for (int o = 0; o < NCH; o++) begin
      for (int i = 0; i < NCH; i++) wb[o][i] = 9'h1FF;
      sc[o] = 256; bi[o] = 0;
    end
    load_all();
    fill_img(4, 3, 0);
    run_frame(4, 3, 0, 100, 100, "R7");

    // R8: random weights, scales and biases through the write port
    rand_params();
    load_all();
    fill_img(7, 5, 1);
    run_frame(7, 5, 0, 70, 60, "R8");

    // R9: next frame without reset, new data, same configuration
    fill_img(7, 5, 1);
    run_frame(7, 5, 0, 80, 70, "R9");

    // R3: saturation both ways; even outputs all add, odd outputs all subtract
    for (int o = 0; o < NCH; o++) begin
      for (int i = 0; i < NCH; i++) wb[o][i] = (o % 2 == 0) ? 9'h1FF : 9'h000;
      sc[o] = 512; bi[o] = 0;
    end
    load_all();
    fill_img(5, 4, 2);
    run_frame(5, 4, 0, 90, 90, "R3");

    // R4: clamp of negative results
    rand_params();
    load_all();
    fill_img(6, 6, 1);
    run_frame(6, 6, 1, 75, 75, "R4");

    // R10: single pixel, then full width
    fill_img(1, 1, 3);
    run_frame(1, 1, 0, 100, 100, "R10");
    fill_img(MAX_W, 3, 3);
    run_frame(MAX_W, 3, 0, 85, 80, "R10");

    // R6: heavy backpressure
    fill_img(9, 7, 1);
    run_frame(9, 7, 0, 90, 25, "R6");

    // R2: random shapes and parameters, back to back
    for (int f = 0; f < 4; f++) begin
      int w = int'($urandom_range(16, 2));
      int h = int'($urandom_range(10, 2));
      rand_params();
      load_all();
      fill_img(w, h, (f % 2 == 0) ? 1 : 3);
      run_frame(w, h, f[0], 60 + 10*f, 50 + 10*f, "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule